// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading two table entries from memory. The top ten bits of the address pick an entry in a directory page. That page starts at a base address held in a register inside the block. The directory entry names the page that holds the second-level table. The next ten bits pick an entry there, and that entry supplies the physical frame. The low twelve bits pass through unchanged as the byte offset inside a 4 KB page.

The CPU side uses a simple request/response pair. A request is taken only while the walker is idle. The result comes back as a one-cycle response carrying either the physical address or a fault. A fault reports the table level that stopped the walk and the virtual address that caused it. The memory side is one 32-bit read port. The walker raises a one-cycle read strobe with an address and then waits for a data strobe, which may arrive in the same cycle or any later cycle.

Top module: `pt_walker`

## Requirements
- R1: After reset, reqReady is 1, and rspValid and memReqValid are 0.
- R2: The first memory read of a walk uses address dirBase + vaddr[31:22]*4, where dirBase is the register value when the request is accepted. The read strobe rises in the cycle after acceptance.
- R3: The second read uses address (first entry bits 31:12 shifted left by 12) + vaddr[21:12]*4.
- R4: On success, rspPaddr = {second entry bits 31:12, vaddr[11:0]} and rspFault = 0. rspValid is high for exactly one cycle, and reqReady is 1 in the next cycle.
- R5: A successful walk makes exactly two memory reads, and each read strobe lasts one cycle.
- R6: Bit 0 of an entry is its valid flag, and the other low bits are ignored. If the directory entry has bit 0 = 0, the walk ends after one read with rspFault = 1, rspFaultLevel = 0 and rspFaultVaddr = vaddr.
- R7: If the second-level entry has bit 0 = 0, the walk ends after two reads with rspFault = 1, rspFaultLevel = 1 and rspFaultVaddr = vaddr.
- R8: reqValid has no effect while reqReady is 0. It does not change the current result and it starts no extra reads.
- R9: The walker holds each step until memRspValid arrives, whether the data comes in the same cycle as the strobe or several cycles later.
- R10: Writing baseWrData with baseWrEn changes the directory base used by requests accepted afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baseWrEn | input | 1 | Write strobe for the directory base register |
| baseWrData | input | 32 | New directory base |
| reqValid | input | 1 | Translation request |
| reqVaddr | input | 32 | Virtual address to translate |
| reqReady | output | 1 | Walker idle; a request is taken this cycle |
| rspValid | output | 1 | One-cycle result strobe |
| rspFault | output | 1 | Result is a fault |
| rspFaultLevel | output | 1 | 0 = directory entry invalid, 1 = second-level entry invalid |
| rspPaddr | output | 32 | Translated physical address |
| rspFaultVaddr | output | 32 | Virtual address of the walk just finished |
| memReqValid | output | 1 | Memory read strobe |
| memReqAddr | output | 32 | Memory read address |
| memRspValid | input | 1 | Memory data strobe |
| memRspData | input | 32 | Memory read data |

## Verification
A wrong control state shows up quickly at the ports, usually within one or two cycles. It appears as a read strobe that lasts two cycles, an extra or missing read, or a response that stays high. A wrong captured address or wrong entry field instead shows up in the address of the second read. The final paddr or fault fields carry it only when the walk completes. The bench therefore checks each read address as well as the final result, with zero and non-zero memory latency. It also checks that the walker returns to idle in the cycle right after the response.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  localparam int ENTRY_VALID_BIT = 0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ_OUTER,
    ST_READ_INNER,
    ST_DONE,
    ST_FAULT
  } walkState_t;

  typedef struct packed {
    logic latchReq;
    logic latchDir;
    logic latchFrame;
    logic latchFault;
    logic faultLevel;
  } walkStrobe_t;

endpackage

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        memRspValid,
  input  logic        entryValid,
  output logic        reqReady,
  output logic        memReqValid,
  output logic        rspValid,
  output logic        rspFault,
  output walkStrobe_t strb
);

  walkState_t stateQ, stateNxt;
  logic       waitQ;
  logic       inRead;

  assign inRead      = (stateQ == ST_READ_OUTER) || (stateQ == ST_READ_INNER);
  assign memReqValid = inRead && !waitQ;
  assign reqReady    = (stateQ == ST_IDLE);
  assign rspValid    = (stateQ == ST_DONE) || (stateQ == ST_FAULT);
  assign rspFault    = (stateQ == ST_FAULT);

  always_comb begin
    stateNxt = stateQ;
    strb     = '0;
    case (stateQ)
      ST_IDLE: begin
        if (reqValid) begin
          strb.latchReq = 1'b1;
          stateNxt      = ST_READ_OUTER;
        end
      end
      ST_READ_OUTER: begin
        if (memRspValid) begin
          if (entryValid) begin
            strb.latchDir = 1'b1;
            stateNxt      = ST_READ_INNER;
          end else begin
            strb.latchFault = 1'b1;
            strb.faultLevel = 1'b0;
            stateNxt        = ST_FAULT;
          end
        end
      end
      ST_READ_INNER: begin
        if (memRspValid) begin
          if (entryValid) begin
            strb.latchFrame = 1'b1;
            stateNxt        = ST_DONE;
          end else begin
            strb.latchFault = 1'b1;
            strb.faultLevel = 1'b1;
            stateNxt        = ST_FAULT;
          end
        end
      end
      ST_DONE, ST_FAULT: stateNxt = ST_IDLE;
      default:           stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      waitQ  <= 1'b0;
    end else begin
      stateQ <= stateNxt;
      if (!inRead || memRspValid) begin
        waitQ <= 1'b0;
      end else if (memReqValid) begin
        waitQ <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/ptw_datapath.sv
module ptw_datapath
  import ptw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baseWrEn,
  input  logic [ADDR_W-1:0] baseWrData,
  input  logic [ADDR_W-1:0] reqVaddr,
  input  walkStrobe_t       strb,
  input  logic [ADDR_W-1:0] memRspData,
  output logic              entryValid,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [ADDR_W-1:0] rspPaddr,
  output logic              rspFaultLevel,
  output logic [ADDR_W-1:0] rspFaultVaddr
);

  localparam int FRAME_W     = ADDR_W - OFF_W;
  localparam int ENTRY_SHIFT = 2;
  localparam int INNER_LO    = OFF_W;
  localparam int OUTER_LO    = OFF_W + IDX_W;

  logic [ADDR_W-1:0]  baseQ, vaddrQ, memAddrQ, paddrQ;
  logic               faultLvlQ;
  logic [IDX_W-1:0]   outerIdx, innerIdx;
  logic [FRAME_W-1:0] entryFrame;
  logic [ADDR_W-1:0]  outerAddr, innerAddr;

  assign outerIdx   = reqVaddr[OUTER_LO +: IDX_W];
  assign innerIdx   = vaddrQ[INNER_LO +: IDX_W];
  assign entryFrame = memRspData[ADDR_W-1:OFF_W];
  assign entryValid = memRspData[ENTRY_VALID_BIT];
  assign outerAddr  = baseQ + (ADDR_W'(outerIdx) << ENTRY_SHIFT);
  assign innerAddr  = {entryFrame, {OFF_W{1'b0}}} + (ADDR_W'(innerIdx) << ENTRY_SHIFT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ     <= '0;
      vaddrQ    <= '0;
      memAddrQ  <= '0;
      paddrQ    <= '0;
      faultLvlQ <= 1'b0;
    end else begin
      if (baseWrEn) baseQ <= baseWrData;
      if (strb.latchReq) begin
        vaddrQ   <= reqVaddr;
        memAddrQ <= outerAddr;
      end
      if (strb.latchDir)   memAddrQ  <= innerAddr;
      if (strb.latchFrame) paddrQ    <= {entryFrame, vaddrQ[OFF_W-1:0]};
      if (strb.latchFault) faultLvlQ <= strb.faultLevel;
    end
  end

  assign memReqAddr    = memAddrQ;
  assign rspPaddr      = paddrQ;
  assign rspFaultLevel = faultLvlQ;
  assign rspFaultVaddr = vaddrQ;

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baseWrEn,
  input  logic [ADDR_W-1:0] baseWrData,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqVaddr,
  output logic              reqReady,
  output logic              rspValid,
  output logic              rspFault,
  output logic              rspFaultLevel,
  output logic [ADDR_W-1:0] rspPaddr,
  output logic [ADDR_W-1:0] rspFaultVaddr,
  output logic              memReqValid,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRspValid,
  input  logic [ADDR_W-1:0] memRspData
);

  walkStrobe_t strb;
  logic        entryValid;

  ptw_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .memRspValid (memRspValid),
    .entryValid  (entryValid),
    .reqReady    (reqReady),
    .memReqValid (memReqValid),
    .rspValid    (rspValid),
    .rspFault    (rspFault),
    .strb        (strb)
  );

  ptw_datapath #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W),
    .OFF_W  (OFF_W)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .baseWrEn      (baseWrEn),
    .baseWrData    (baseWrData),
    .reqVaddr      (reqVaddr),
    .strb          (strb),
    .memRspData    (memRspData),
    .entryValid    (entryValid),
    .memReqAddr    (memReqAddr),
    .rspPaddr      (rspPaddr),
    .rspFaultLevel (rspFaultLevel),
    .rspFaultVaddr (rspFaultVaddr)
  );

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [ADDR_W-1:0] reqVaddr,
  input logic              reqReady,
  input logic              rspValid,
  input logic              rspFault,
  input logic [ADDR_W-1:0] rspPaddr,
  input logic [ADDR_W-1:0] rspFaultVaddr,
  input logic              memReqValid,
  input logic              memRspValid
);

  logic [ADDR_W-1:0] savedQ;

  always_ff @(posedge clk) begin
    if (!rstN)                      savedQ <= '0;
    else if (reqValid && reqReady)  savedQ <= reqVaddr;
  end

  // R2
  first_read_next_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> memReqValid);

  // R5
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memRspValid |=> !memReqValid);

  // R8
  no_read_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !reqReady);

  // R4
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid && reqReady);

  // R4
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspFault |-> rspPaddr[OFF_W-1:0] == savedQ[OFF_W-1:0]);

  // R6
  fault_vaddr_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspFault |-> rspFaultVaddr == savedQ);

endmodule

bind pt_walker pt_walker_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .reqValid      (reqValid),
  .reqVaddr      (reqVaddr),
  .reqReady      (reqReady),
  .rspValid      (rspValid),
  .rspFault      (rspFault),
  .rspPaddr      (rspPaddr),
  .rspFaultVaddr (rspFaultVaddr),
  .memReqValid   (memReqValid),
  .memRspValid   (memRspValid)
);

// File: tb/pt_walker_tb.sv
module pt_walker_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 7;
  // {vaddr, latency}
  localparam logic [33:0] VECS [NVEC] = '{
    {32'h0040_5123, 2'd0},
    {32'h0040_0FFF, 2'd1},
    {32'h007F_F000, 2'd3},
    {32'h0040_7456, 2'd2},
    {32'h0080_0ABC, 2'd0},
    {32'hFFFF_FFFF, 2'd2},
    {32'h0000_0010, 2'd1}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        baseWrEn = 1'b0;
  logic [31:0] baseWrData = '0;
  logic        reqValid = 1'b0;
  logic [31:0] reqVaddr = '0;
  logic        reqReady, rspValid, rspFault, rspFaultLevel, memReqValid;
  logic [31:0] rspPaddr, rspFaultVaddr, memReqAddr;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;

  int total = 0;
  int bad = 0;

  logic [31:0] memArr [logic [31:0]];
  logic [31:0] benchBase;
  int          memLat = 0;
  int          readCnt = 0;
  logic [31:0] readAddr [4];
  logic        busy = 1'b0;
  int          cnt = 0;
  logic [31:0] pendAddr;

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_walker u_dut (
    .clk(clk), .rstN(rstN), .baseWrEn(baseWrEn), .baseWrData(baseWrData),
    .reqValid(reqValid), .reqVaddr(reqVaddr), .reqReady(reqReady),
    .rspValid(rspValid), .rspFault(rspFault), .rspFaultLevel(rspFaultLevel),
    .rspPaddr(rspPaddr), .rspFaultVaddr(rspFaultVaddr),
    .memReqValid(memReqValid), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData)
  );

  function automatic logic [31:0] rd(input logic [31:0] a);
    return memArr.exists(a) ? memArr[a] : 32'h0;
  endfunction

  // Memory model: answers `memLat` cycles after the read strobe.
  always @(negedge clk) begin
    memRspValid = 1'b0;
    if (busy) begin
      if (cnt == 0) begin
        memRspValid = 1'b1;
        memRspData  = rd(pendAddr);
        busy        = 1'b0;
      end else cnt = cnt - 1;
    end else if (rstN && memReqValid) begin
      if (readCnt < 4) readAddr[readCnt] = memReqAddr;
      readCnt  = readCnt + 1;
      pendAddr = memReqAddr;
      if (memLat == 0) begin
        memRspValid = 1'b1;
        memRspData  = rd(pendAddr);
      end else begin
        busy = 1'b1;
        cnt  = memLat - 1;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doWalk(input logic [31:0] va, input int lat, input bit intrude);
    logic [31:0] e1, e2, d, t, expPa;
    int kind;
    bit seen;
    e1 = benchBase + {20'h0, va[31:22], 2'b00};
    d  = rd(e1);
    e2 = '0; expPa = '0;
    if (!d[0]) kind = 1;
    else begin
      e2 = {d[31:12], 12'h0} + {20'h0, va[21:12], 2'b00};
      t  = rd(e2);
      if (!t[0]) kind = 2;
      else begin kind = 0; expPa = {t[31:12], va[11:0]}; end
    end
    memLat  = lat;
    readCnt = 0;
    @(negedge clk);
    reqValid = 1'b1; reqVaddr = va;
    @(negedge clk);
    reqValid = 1'b0;
    seen = 0;
    for (int i = 0; i < 40 && !seen; i++) begin
      if (rspValid) seen = 1;
      else begin
        if (intrude && i < 2) begin reqValid = 1'b1; reqVaddr = 32'h0080_0ABC; end
        else reqValid = 1'b0;
        @(negedge clk);
      end
    end
    reqValid = 1'b0;
    chk("R9 response arrived", {31'h0, seen}, 32'h1);
    chk("R2 first read address", readAddr[0], e1);
    if (kind == 1) begin
      chk("R6 read count on outer fault", readCnt, 1);
      chk("R6 fault flag", {31'h0, rspFault}, 32'h1);
      chk("R6 fault level", {31'h0, rspFaultLevel}, 32'h0);
      chk("R6 fault vaddr", rspFaultVaddr, va);
    end else begin
      chk("R3 second read address", readAddr[1], e2);
      chk("R5 read count", readCnt, 2);
      if (kind == 2) begin
        chk("R7 fault flag", {31'h0, rspFault}, 32'h1);
        chk("R7 fault level", {31'h0, rspFaultLevel}, 32'h1);
        chk("R7 fault vaddr", rspFaultVaddr, va);
      end else begin
        chk("R4 no fault", {31'h0, rspFault}, 32'h0);
        chk("R4 physical address", rspPaddr, expPa);
      end
    end
    @(negedge clk);
    chk("R4 response one cycle", {31'h0, rspValid}, 32'h0);
    chk("R4 back to ready", {31'h0, reqReady}, 32'h1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    benchBase = 32'h0010_0000;
    memArr[32'h0010_0004] = 32'h0020_0001;
    memArr[32'h0010_0FFC] = 32'h0030_0001;
    memArr[32'h0010_0008] = 32'h0040_0000;
    memArr[32'h0020_0014] = 32'hABCD_E001;
    memArr[32'h0020_0000] = 32'h1234_5003;
    memArr[32'h0020_0FFC] = 32'h0000_0001;
    memArr[32'h0020_001C] = 32'h7777_7000;
    memArr[32'h0030_0FFC] = 32'hFFFF_F001;
    memArr[32'h0050_0004] = 32'h0020_0001;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reqReady in reset", {31'h0, reqReady}, 32'h1);
    chk("R1 rspValid in reset", {31'h0, rspValid}, 32'h0);
    chk("R1 memReqValid in reset", {31'h0, memReqValid}, 32'h0);
    rstN = 1'b1;
    baseWrEn = 1'b1; baseWrData = benchBase;
    @(negedge clk);
    baseWrEn = 1'b0;
    chk("R1 idle after reset", {31'h0, reqReady}, 32'h1);

    for (int v = 0; v < NVEC; v++)
      doWalk(VECS[v][33:2], int'(VECS[v][1:0]), 1'b0);

    // R8: request pulses during a walk are ignored
    doWalk(32'h0040_5123, 2, 1'b1);
    readCnt = 0;
    repeat (5) @(negedge clk);
    chk("R8 no extra reads after ignored request", readCnt, 0);
    chk("R8 still idle", {31'h0, reqReady}, 32'h1);

    // R10: new directory base applies to next request
    @(negedge clk);
    baseWrEn = 1'b1; baseWrData = 32'h0050_0000; benchBase = 32'h0050_0000;
    @(negedge clk);
    baseWrEn = 1'b0;
    doWalk(32'h0040_5123, 1, 1'b0);
    chk("R10 read uses new base", readAddr[0], 32'h0050_0004);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule